// File: doc/BRIEF.md
# Execution / Memory-Wait Tick Meter

This block is a performance meter that runs on the memory-side clock. It assigns every memory-clock tick to one of two buckets. A tick goes to the memory-wait bucket when the execution unit is truly stalled on memory. Every other tick goes to the execution bucket. Each bucket has its own saturating counter, and software can read it, freeze it or clear it.

The stall qualifier combines four inputs. The first is the execution-clock sync level, which is high in the memory tick just before the next execution clock. The second is the memory-wait flag. The third is the accumulator-reference flag, which blocks the qualifier because such references never wait. The fourth is the transfer-complete pulse. The transfer-complete term makes the qualifier drop one tick before the wait flag clears. As a result, the last tick of a stall, where memory has already answered, goes to execution.

Top module: `exec_wait_meter`

## Requirements
- R1: After reset both counters read zero.
- R2: On each enabled tick with clear low, exactly one counter advances by one. The wait counter advances when exec_sync, mem_wait, not acc_ref and not xfer_done are all true. Otherwise the execution counter advances.
- R3: A tick with acc_ref high is charged to execution even when exec_sync and mem_wait are high.
- R4: A tick with xfer_done high is charged to execution even when exec_sync and mem_wait are high.
- R5: A counter that reaches its all-ones value (2^CNT_W - 1) stays there and does not wrap.
- R6: When clear is high at a tick, both counters are zero after that tick, whatever count_en is.
- R7: When count_en is low and clear is low, both counters hold their values.
- R8: A loop of four microinstructions, three of two ticks and one memory-wait microinstruction of three ticks, adds exactly 8 to the execution counter and 1 to the wait counter per pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous clear of both counters |
| count_en | input | 1 | Counting enable; low freezes the counters |
| exec_sync | input | 1 | High in the tick before the next execution clock |
| mem_wait | input | 1 | Execution unit is requesting a memory wait |
| acc_ref | input | 1 | Current reference targets the accumulators |
| xfer_done | input | 1 | Memory signals transfer complete this tick |
| exec_count | output | CNT_W | Ticks charged to execution |
| wait_count | output | CNT_W | Ticks charged to memory wait |

## Verification
The bench replays the four-microinstruction loop. A design without the transfer-complete term would charge the last stall tick to waiting and report 7 execution ticks and 2 wait ticks per pass. It also places the accumulator-reference and transfer-complete pulses in ticks where sync and wait are high, which catches a qualifier that ignores either one. Both counters are driven past their limit in a narrowed instance, where a wrapping counter would fall back to zero. Clear is asserted together with enable to show that clear wins, and enable is dropped during stall ticks to show that neither counter moves.

// File: rtl/exec_wait_meter.sv
module exec_wait_meter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             count_en,
  input  logic             exec_sync,
  input  logic             mem_wait,
  input  logic             acc_ref,
  input  logic             xfer_done,
  output logic [CNT_W-1:0] exec_count,
  output logic [CNT_W-1:0] wait_count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic stalled;
  assign stalled = exec_sync & mem_wait & ~acc_ref & ~xfer_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exec_count <= '0;
      wait_count <= '0;
    end else if (clear) begin
      exec_count <= '0;
      wait_count <= '0;
    end else if (count_en) begin
      if (stalled) begin
        if (wait_count != CNT_MAX) wait_count <= wait_count + 1'b1;
      end else begin
        if (exec_count != CNT_MAX) exec_count <= exec_count + 1'b1;
      end
    end
  end

  assert_one_charge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && !clear && exec_count != CNT_MAX && wait_count != CNT_MAX) |=>
    ({1'b0, exec_count} + {1'b0, wait_count} ==
     {1'b0, $past(exec_count)} + {1'b0, $past(wait_count)} + 1'b1));

  assert_acc_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && !clear && acc_ref) |=> $stable(wait_count));

  assert_xfer_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && !clear && xfer_done) |=> $stable(wait_count));

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && exec_count == CNT_MAX && wait_count == CNT_MAX) |=>
    (exec_count == CNT_MAX && wait_count == CNT_MAX));

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (exec_count == '0 && wait_count == '0));

  assert_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!count_en && !clear) |=> ($stable(exec_count) && $stable(wait_count)));
endmodule

// File: tb/exec_wait_meter_bench.sv
module exec_wait_meter_bench;
  localparam int W = 6;
  localparam int MAXV = (1 << W) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic clear = 0, count_en = 0, exec_sync = 0, mem_wait = 0, acc_ref = 0, xfer_done = 0;
  logic [W-1:0] exec_count, wait_count;

  int vectors = 0, fails = 0;
  int exp_e = 0, exp_w = 0;
  int qe[$], qw[$];
  string qr[$];

  always #4 clk = ~clk;

  exec_wait_meter #(.CNT_W(W)) u_exec_wait_meter (
    .clk(clk), .rst_n(rst_n), .clear(clear), .count_en(count_en),
    .exec_sync(exec_sync), .mem_wait(mem_wait), .acc_ref(acc_ref),
    .xfer_done(xfer_done), .exec_count(exec_count), .wait_count(wait_count));

  task automatic check(input string req, input int act_e, input int act_w,
                       input int ex_e, input int ex_w);
    vectors++;
    if (act_e != ex_e || act_w != ex_w) begin
      fails++;
      $display("FAIL %s: exec=%0d wait=%0d expected exec=%0d wait=%0d",
               req, act_e, act_w, ex_e, ex_w);
    end
  endtask

  task automatic tick(input logic s, input logic mw, input logic ac,
                      input logic xd, input logic cl, input logic en,
                      input string req);
    exec_sync = s; mem_wait = mw; acc_ref = ac; xfer_done = xd;
    clear = cl; count_en = en;
    if (cl) begin
      exp_e = 0; exp_w = 0;
    end else if (en) begin
      if (s && mw && !ac && !xd) begin
        if (exp_w < MAXV) exp_w++;
      end else begin
        if (exp_e < MAXV) exp_e++;
      end
    end
    @(posedge clk);
    #1;
    qe.push_back(exp_e); qw.push_back(exp_w); qr.push_back(req);
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (qe.size() > 0)
      check(qr.pop_front(), int'(exec_count), int'(wait_count),
            qe.pop_front(), qw.pop_front());
  end

  task automatic run_loop;
    tick(0, 0, 0, 0, 0, 1, "R8");
    tick(1, 0, 0, 0, 0, 1, "R8");
    tick(0, 0, 0, 0, 0, 1, "R8");
    tick(1, 1, 0, 0, 0, 1, "R8");
    tick(1, 1, 0, 1, 0, 1, "R8");
    tick(0, 0, 0, 0, 0, 1, "R8");
    tick(1, 0, 0, 0, 0, 1, "R8");
    tick(0, 0, 0, 0, 0, 1, "R8");
    tick(1, 0, 0, 0, 0, 1, "R8");
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: exec=%0d wait=%0d expected run to finish", exec_count, wait_count);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", int'(exec_count), int'(wait_count), 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'(exec_count), int'(wait_count), 0, 0);

    tick(0, 0, 0, 0, 0, 1, "R2 idle");
    tick(1, 0, 0, 0, 0, 1, "R2 sync only");
    tick(0, 1, 0, 0, 0, 1, "R2 wait only");
    tick(1, 1, 0, 0, 0, 1, "R2 stalled");
    tick(1, 1, 0, 0, 0, 1, "R2 stalled");
    tick(1, 1, 1, 0, 0, 1, "R3 acc ref");
    tick(1, 1, 0, 1, 0, 1, "R4 xfer done");
    tick(1, 1, 0, 0, 0, 0, "R7 freeze stall");
    tick(0, 0, 0, 0, 0, 0, "R7 freeze idle");
    tick(1, 1, 0, 0, 1, 1, "R6 clear wins");
    tick(1, 1, 0, 0, 1, 0, "R6 clear disabled");

    for (int i = 0; i < 3; i++) begin
      int e0, w0;
      e0 = int'(exec_count); w0 = int'(wait_count);
      run_loop();
      check("R8 per pass", int'(exec_count) - e0, int'(wait_count) - w0, 8, 1);
    end

    for (int i = 0; i < 50; i++) tick(0, 0, 0, 0, 0, 1, "R5 exec sat");
    for (int i = 0; i < 70; i++) tick(1, 1, 0, 0, 0, 1, "R5 wait sat");
    check("R5 both max", int'(exec_count), int'(wait_count), MAXV, MAXV);
    tick(0, 0, 0, 0, 1, 1, "R6 clear after sat");

    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule